// File: doc/BRIEF.md
# Six-Pin GPIO Port with Change Detection

This block is a small bidirectional I/O port of six pins, reached through a register strobe interface with an 8-bit data bus. Software sets each pin's direction and drives outputs through an output latch. Each pin also has a pull-up request, and a pin is pulled up only when its own enable is set, the chip-wide pull-up enable input is high and the pin is an input. Reading the data register returns the synchronized pin levels rather than the output latch. Pin 3 is input-only.

Each pin can also take part in change detection. Every read or write of the data register stores the synchronized pin levels in a snapshot. An enabled pin whose level differs from the snapshot sets a sticky change flag, and that flag also drives a wake request. The flag keeps setting itself while the difference remains. Software ends the difference by touching the data register and then clears the flag by writing 0 to the flag register.

Top module: `gpio_ioc_port`

## Requirements
- R1: After reset the direction register reads 0x3F (all inputs), the pull-up register reads 0x37, the change-enable register reads 0x00, the flag register reads 0x00, and pin_out, pin_oe, chg_flag and wake_req are all 0.
- R2: Register map: address 0 is port data, 1 is direction, 2 is pull-up enable, 3 is change enable, 4 is the flag register (flag in bit 0), and every other address reads 0. Bits 7 and 6 of every register read 0. Direction bit 3 always reads 1 and pin_oe[3] is never 1. Pull-up bit 3 always reads 0.
- R3: A pin whose change-enable bit is 0 never causes the flag to set, whatever its level does.
- R4: When the synchronized level of an enabled pin differs from the snapshot, chg_flag becomes 1. A level change at pin_in shows on chg_flag at the third rising clock edge after it, because the pins pass through two synchronizer flops.
- R5: A read or a write of the data register loads the snapshot with the synchronized pin levels, which ends any mismatch.
- R6: Writing a value with bit 0 equal to 0 to the flag register clears the flag, and writing bit 0 equal to 1 has no effect. While a mismatch persists the flag stays set, because a set and a clear in the same cycle resolve to set.
- R7: If the synchronized level changes in the same cycle as a data register access, the change is missed: the snapshot takes the new level and the flag does not set.
- R8: pull_en[i] is 1 exactly when pull-up bit i is 1, pull_global_en is 1 and direction bit i is 1.
- R9: A data register write sets the output latch that drives pin_out. A data register read returns the synchronized pin_in levels. pin_oe[i] is the inverse of direction bit i, where a direction bit of 1 means input.
- R10: wake_req is equal to chg_flag at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Single-cycle access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of the strobe |
| pull_global_en | input | 1 | Chip-wide pull-up enable |
| pin_in | input | 6 | Pad input levels (asynchronous) |
| pin_out | output | 6 | Output latch to pads |
| pin_oe | output | 6 | Pad output enable, 1 = drive |
| pull_en | output | 6 | Pull-up request per pad |
| chg_flag | output | 1 | Sticky change flag |
| wake_req | output | 1 | Wake-from-sleep request |

## Verification
The bench times the flag against the synchronizer depth. A design with the wrong number of stages raises the flag one cycle early or one cycle late. It changes a pin so that the synchronized level moves in the exact cycle of a port read. A design that does not suppress the set in that cycle would raise a flag that should be missed. It tries to clear the flag while a mismatch is still present. A design where the clear wins would drop the flag, or would never re-latch the snapshot. Random register traffic and pin changes with disabled enables check that masked pins, the fixed bits of pin 3 and the unimplemented upper bits never show through.

// File: rtl/gpio_ioc_pkg.sv
package gpio_ioc_pkg;
  localparam int BUS_DW = 8;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_DATA  = 3'd0,
    REG_DIR   = 3'd1,
    REG_PULL  = 3'd2,
    REG_CHGEN = 3'd3,
    REG_FLAG  = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 6,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [W-1:0] stage_d;
    if (g == 0) begin : g_first
      assign stage_d = din;
    end else begin : g_next
      assign stage_d = stage_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[g] <= '0;
      else        stage_q[g] <= stage_d;
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_ioc_pkg::*;
#(
  parameter int              PINS      = 6,
  parameter logic [PINS-1:0] IN_ONLY   = 6'b001000,
  parameter logic [PINS-1:0] PULL_IMPL = 6'b110111
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_we,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [BUS_DW-1:0] acc_wdata,
  input  logic [PINS-1:0]   pin_sync,
  input  logic              flag,
  output logic [BUS_DW-1:0] acc_rdata,
  output logic [PINS-1:0]   out_latch,
  output logic [PINS-1:0]   dir_eff,
  output logic [PINS-1:0]   pull_bits,
  output logic [PINS-1:0]   chg_en,
  output logic              port_acc,
  output logic              flag_clr
);
  logic [PINS-1:0] out_q, out_d, dir_q, dir_d, pull_q, pull_d, chg_q, chg_d;
  logic            out_en, dir_en, pull_en_w, chg_en_w;
  logic            wr;
  logic            unused_wdata;

  assign wr           = acc_valid & acc_we;
  assign port_acc     = acc_valid & (acc_addr == REG_DATA);
  assign flag_clr     = wr & (acc_addr == REG_FLAG) & ~acc_wdata[0];
  assign unused_wdata = ^acc_wdata[BUS_DW-1:PINS];

  // next-state decode
  always_comb begin
    out_en    = wr & (acc_addr == REG_DATA);
    dir_en    = wr & (acc_addr == REG_DIR);
    pull_en_w = wr & (acc_addr == REG_PULL);
    chg_en_w  = wr & (acc_addr == REG_CHGEN);
    out_d     = acc_wdata[PINS-1:0];
    dir_d     = acc_wdata[PINS-1:0] | IN_ONLY;
    pull_d    = acc_wdata[PINS-1:0] & PULL_IMPL;
    chg_d     = acc_wdata[PINS-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      dir_q  <= '1;
      pull_q <= PULL_IMPL;
      chg_q  <= '0;
    end else begin
      if (out_en)    out_q  <= out_d;
      if (dir_en)    dir_q  <= dir_d;
      if (pull_en_w) pull_q <= pull_d;
      if (chg_en_w)  chg_q  <= chg_d;
    end
  end

  assign out_latch = out_q;
  assign dir_eff   = dir_q | IN_ONLY;
  assign pull_bits = pull_q & PULL_IMPL;
  assign chg_en    = chg_q;

  // read mux, zero-extended to the bus width
  always_comb begin
    acc_rdata = '0;
    if (acc_valid && !acc_we) begin
      case (acc_addr)
        REG_DATA:  acc_rdata = BUS_DW'(pin_sync);
        REG_DIR:   acc_rdata = BUS_DW'(dir_eff);
        REG_PULL:  acc_rdata = BUS_DW'(pull_bits);
        REG_CHGEN: acc_rdata = BUS_DW'(chg_q);
        REG_FLAG:  acc_rdata = BUS_DW'(flag);
        default:   acc_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_chg_detect.sv
module gpio_chg_detect #(
  parameter int PINS = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] pin_sync,
  input  logic [PINS-1:0] chg_en,
  input  logic            port_acc,
  input  logic            flag_clr,
  output logic [PINS-1:0] snap,
  output logic            mismatch,
  output logic            flag
);
  logic [PINS-1:0] snap_q, snap_d, diff;
  logic            flag_q, flag_d, flag_set;

  assign diff     = (pin_sync ^ snap_q) & chg_en;
  assign mismatch = |diff;
  // a change seen in the access cycle is absorbed by the new snapshot
  assign flag_set = mismatch & ~port_acc;

  always_comb begin
    snap_d = pin_sync;
    if (flag_set)      flag_d = 1'b1;
    else if (flag_clr) flag_d = 1'b0;
    else               flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '0;
      flag_q <= 1'b0;
    end else begin
      if (port_acc) snap_q <= snap_d;
      flag_q <= flag_d;
    end
  end

  assign snap = snap_q;
  assign flag = flag_q;
endmodule

// File: rtl/gpio_ioc_port.sv
module gpio_ioc_port
  import gpio_ioc_pkg::*;
#(
  parameter int              PINS        = 6,
  parameter int              SYNC_STAGES = 2,
  parameter logic [PINS-1:0] IN_ONLY     = 6'b001000,
  parameter logic [PINS-1:0] PULL_IMPL   = 6'b110111
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_DW-1:0] bus_wdata,
  output logic [BUS_DW-1:0] bus_rdata,
  input  logic              pull_global_en,
  input  logic [PINS-1:0]   pin_in,
  output logic [PINS-1:0]   pin_out,
  output logic [PINS-1:0]   pin_oe,
  output logic [PINS-1:0]   pull_en,
  output logic              chg_flag,
  output logic              wake_req
);
  logic [PINS-1:0] pin_sync, out_latch, dir_eff, pull_bits, chg_en, snap;
  logic            port_acc, flag_clr, mismatch, flag;

  gpio_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pin_in), .dout(pin_sync)
  );

  gpio_regs #(.PINS(PINS), .IN_ONLY(IN_ONLY), .PULL_IMPL(PULL_IMPL)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(bus_sel), .acc_we(bus_we), .acc_addr(bus_addr),
    .acc_wdata(bus_wdata), .pin_sync(pin_sync), .flag(flag),
    .acc_rdata(bus_rdata), .out_latch(out_latch), .dir_eff(dir_eff),
    .pull_bits(pull_bits), .chg_en(chg_en),
    .port_acc(port_acc), .flag_clr(flag_clr)
  );

  gpio_chg_detect #(.PINS(PINS)) u_chg (
    .clk(clk), .rst_n(rst_n), .pin_sync(pin_sync), .chg_en(chg_en),
    .port_acc(port_acc), .flag_clr(flag_clr),
    .snap(snap), .mismatch(mismatch), .flag(flag)
  );

  assign pin_out  = out_latch;
  assign pin_oe   = ~dir_eff;
  assign pull_en  = pull_bits & {PINS{pull_global_en}} & dir_eff;
  assign chg_flag = flag;
  assign wake_req = flag;
endmodule

// File: rtl/gpio_ioc_port_chk.sv
module gpio_ioc_port_chk #(
  parameter int PINS = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PINS-1:0] pin_sync,
  input logic [PINS-1:0] snap,
  input logic [PINS-1:0] chg_en,
  input logic [PINS-1:0] pin_oe,
  input logic [PINS-1:0] pull_en,
  input logic            port_acc,
  input logic            flag_clr,
  input logic            mismatch,
  input logic            chg_flag,
  input logic            wake_req
);
  assert_flag_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mismatch && !port_acc) |=> chg_flag);

  assert_masked_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!chg_flag && chg_en == '0) |=> !chg_flag);

  assert_snapshot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    port_acc |=> (snap == $past(pin_sync)));

  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !mismatch) |=> !chg_flag);

  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_flag && !flag_clr) |=> chg_flag);

  assert_missed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (port_acc && !chg_flag && !flag_clr) |=> !chg_flag);

  assert_no_pull_on_driver_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pull_en & pin_oe) == '0);

  assert_wake_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req == chg_flag);
endmodule

bind gpio_ioc_port gpio_ioc_port_chk #(.PINS(PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .pin_sync(pin_sync), .snap(snap),
  .chg_en(chg_en), .pin_oe(pin_oe), .pull_en(pull_en),
  .port_acc(port_acc), .flag_clr(flag_clr), .mismatch(mismatch),
  .chg_flag(chg_flag), .wake_req(wake_req)
);

// File: tb/tb_gpio_ioc_port.sv
module tb_gpio_ioc_port;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_sel, bus_we;
  logic [2:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic       pull_global_en;
  logic [5:0] pin_in, pin_out, pin_oe, pull_en;
  logic       chg_flag, wake_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam logic [5:0] PMASK = 6'b110111;
  localparam logic [5:0] IONLY = 6'b001000;

  // reference model
  logic [5:0] m_out, m_dir, m_pu, m_ioc, m_snap;
  logic       m_flag;

  always #5 clk = ~clk;

  gpio_ioc_port dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pull_global_en(pull_global_en), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .pull_en(pull_en), .chg_flag(chg_flag), .wake_req(wake_req)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic mism();
    return ((pin_in ^ m_snap) & m_ioc) != 6'd0;
  endfunction

  function automatic logic [7:0] exp_rd(logic [2:0] a);
    case (a)
      3'd0: return {2'b00, pin_in};
      3'd1: return {2'b00, m_dir | IONLY};
      3'd2: return {2'b00, m_pu & PMASK};
      3'd3: return {2'b00, m_ioc};
      3'd4: return {7'd0, m_flag};
      default: return 8'h00;
    endcase
  endfunction

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; bus_sel = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    m_out = 0; m_dir = 6'h3F; m_pu = PMASK; m_ioc = 0; m_snap = 0; m_flag = 0;
  endtask

  // all tasks start and end just after a falling edge
  task automatic do_write(logic [2:0] a, logic [7:0] d);
    logic pre = mism();
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
    case (a)
      3'd0: begin m_out = d[5:0]; m_snap = pin_in; end
      3'd1: begin m_dir = d[5:0]; m_flag = m_flag | pre; end
      3'd2: begin m_pu = d[5:0] & PMASK; m_flag = m_flag | pre; end
      3'd3: begin m_ioc = d[5:0]; m_flag = m_flag | pre; end
      3'd4: begin
        if (pre) m_flag = 1'b1;
        else if (!d[0]) m_flag = 1'b0;
      end
      default: m_flag = m_flag | pre;
    endcase
    idle(1);
    m_flag = m_flag | mism();
  endtask

  task automatic do_read(logic [2:0] a, output logic [7:0] r);
    logic pre = mism();
    bus_sel = 1; bus_we = 0; bus_addr = a;
    #1 r = bus_rdata;
    @(negedge clk);
    bus_sel = 0;
    if (a == 3'd0) m_snap = pin_in;
    else m_flag = m_flag | pre;
    idle(1);
    m_flag = m_flag | mism();
  endtask

  task automatic set_pins(logic [5:0] p, logic g);
    pin_in = p; pull_global_en = g;
    idle(3);
    m_flag = m_flag | mism();
  endtask

  task automatic check_outputs(string tag);
    logic [5:0] de = m_dir | IONLY;
    check({tag, " R9 pin_out"}, pin_out, m_out);
    check({tag, " R9 R2 pin_oe"}, pin_oe, ~de);
    check({tag, " R8 pull_en"}, pull_en, m_pu & PMASK & de & {6{pull_global_en}});
    check({tag, " R4 chg_flag"}, chg_flag, m_flag);
    check({tag, " R10 wake_req"}, wake_req, chg_flag);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    void'($urandom(32'd24681));
    pin_in = 6'h00; pull_global_en = 1'b1;
    do_reset();

    // R1 reset state
    do_read(3'd1, r); check("R1 dir reset", r, 8'h3F);
    do_read(3'd2, r); check("R1 pull reset", r, 8'h37);
    do_read(3'd3, r); check("R1 chg-enable reset", r, 8'h00);
    do_read(3'd4, r); check("R1 flag reset", r, 8'h00);
    check("R1 pin_oe reset", pin_oe, 6'h00);
    check("R1 pin_out reset", pin_out, 6'h00);
    check("R1 flag/wake reset", {chg_flag, wake_req}, 2'b00);

    // R2 fixed and unimplemented bits
    do_write(3'd1, 8'h00); do_read(3'd1, r); check("R2 dir bit3 reads 1", r, 8'h08);
    check("R2 pin3 never driven", pin_oe, 6'h37);
    do_write(3'd2, 8'hFF); do_read(3'd2, r); check("R2 pull bit3 reads 0", r, 8'h37);
    check("R8 pulls off on outputs", pull_en, 6'h00);
    do_write(3'd1, 8'hFF); do_read(3'd1, r); check("R2 upper bits read 0", r, 8'h3F);
    check("R8 pulls on inputs", pull_en, 6'h37);
    do_read(3'd6, r); check("R2 unmapped reads 0", r, 8'h00);
    do_write(3'd0, 8'hEA); check("R9 out latch", pin_out, 6'h2A);
    do_read(3'd0, r); check("R9 read returns pins", r, 8'h00);

    // R3 disabled pin changes do not set the flag
    do_write(3'd3, 8'h01);
    pin_in = 6'h3E; idle(5);
    check("R3 masked change", chg_flag, 1'b0);

    // R4 latency: three rising edges
    do_read(3'd0, r);
    pin_in = 6'h3F;
    idle(2); check("R4 not yet at edge 2", chg_flag, 1'b0);
    idle(1); check("R4 set at edge 3", chg_flag, 1'b1);
    check("R10 wake follows", wake_req, 1'b1);

    // R6 clear while mismatch persists
    do_write(3'd4, 8'h00); check("R6 set wins over clear", chg_flag, 1'b1);
    do_write(3'd4, 8'h01); check("R6 writing 1 no effect", chg_flag, 1'b1);
    // R5 port access ends mismatch, then clear works
    do_read(3'd0, r); check("R5 read sees pins", r, 8'h3F);
    do_write(3'd4, 8'hFE); idle(2);
    check("R6 clear after access", chg_flag, 1'b0);
    pin_in = 6'h3E; idle(3); check("R4 fall sets", chg_flag, 1'b1);
    do_write(3'd0, 8'h00); do_write(3'd4, 8'h00); idle(2);
    check("R5 write relatches", chg_flag, 1'b0);

    // R7 change lands in the access cycle
    pin_in = 6'h3F;
    idle(2);
    do_read(3'd0, r);
    check("R7 read returns new level", r, 8'h3F);
    idle(3);
    check("R7 coincident change missed", chg_flag, 1'b0);

    // constrained random phase
    do_reset();
    for (int i = 0; i < 600; i++) begin
      int op = $urandom_range(0, 9);
      if (op < 4) begin
        logic [2:0] a = 3'($urandom_range(0, 6));
        logic [7:0] d = 8'($urandom);
        if (a == 3'd4 && $urandom_range(0, 1) == 0) d[0] = 1'b0;
        do_write(a, d);
        check_outputs("rand-wr");
      end else if (op < 7) begin
        logic [2:0] a = 3'($urandom_range(0, 7));
        logic [7:0] e = exp_rd(a);
        do_read(a, r);
        check("R2 R9 rand read", r, e);
      end else begin
        set_pins(6'($urandom), 1'($urandom));
        check_outputs("rand-pin");
      end
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule